// File: doc/BRIEF.md
# Embedded write busy and polling status engine

This block sits behind a flash command decoder and stands in for the internal program or erase operation that runs after the decoder accepts a complete write sequence. A one-cycle start request carries the operation type, a target address and, for a program, the data word. The block then stays busy for a cycle count fixed by a parameter for each operation type. While it is busy, every read returns a status word instead of array data. Bit 7 is a data-polling bit: it is the inverse of bit 7 of the word being programmed, or zero during any erase. Bit 6 flips on every successive status read.

When the busy count runs out, the block drops busy, raises a one-cycle done pulse and returns to plain array reads. A program writes its word into a behavioural array at the moment the count expires. An erase walks its region, one word per cycle, from the first busy cycle, and this walk ends before the count does. Short parameter values keep simulations fast. The real durations are on the order of tens of microseconds for a program and tens of milliseconds for an erase.

Top module: `pgm_status_engine`

## Requirements
- R1: A start request is accepted only while busy is low. Operation codes are 0 for program, 1 for sector erase, 2 for block erase and 3 for chip erase. Busy goes high in the cycle after an accepted start and stays high for exactly T_PROG, T_SECT, T_BLK or T_CHIP cycles.
- R2: done is high for exactly one cycle, which is the first cycle in which busy is low again after an operation.
- R3: A start request made while busy is ignored. It changes neither the operation in progress, its duration, nor the array contents.
- R4: rd_valid and rd_data appear in the cycle after the cycle in which rd_req is high, for every read.
- R5: A read requested in a cycle where busy is high returns a status word with rd_is_status high. During a program, bit 7 of that word is the inverse of bit 7 of the data being programmed, whatever rd_addr is.
- R6: During any erase, bit 7 of the status word is 0.
- R7: Bit 6 of the status word is 0 on the first status read after a start and inverts on each later status read of the same operation. All status bits other than 7 and 6 are 0.
- R8: A read requested while busy is low returns the array word at rd_addr with rd_is_status low. This includes a read in the cycle where done is high.
- R9: When a program completes, the array word at its address holds the programmed data.
- R10: A sector erase sets to all ones the 2^SECT_AW words of the aligned region that holds the start address. A block erase does the same for 2^BLK_AW words, and a chip erase for every word. Words outside the region are unchanged.
- R11: After reset, busy, done and rd_valid are low, and the array reads all ones from power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | One-cycle request to begin an operation |
| start_op | input | 2 | Operation code: 0 program, 1 sector, 2 block, 3 chip erase |
| start_addr | input | AW | Target word address (any word inside the region for erases) |
| start_data | input | DW | Word to program |
| rd_req | input | 1 | Read request |
| rd_addr | input | AW | Read word address |
| rd_valid | output | 1 | Read result valid, one cycle after rd_req |
| rd_data | output | DW | Array word or status word |
| rd_is_status | output | 1 | High when rd_data is a status word |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when an operation ends |

## Verification
The embedded assertions check, on every cycle, the invariants that hold locally. These are the single-cycle done pulse and its relation to busy, the frozen operation fields under a start made while busy, the one-cycle read latency, the toggle bit inverting on each status read and clearing on start, zero in bit 7 for erase status, and an erase walk that never runs outside the busy window. Only the bench scenarios show the exact busy length for each operation type, bit 7 tracking the programmed word, the switch to array data in the done cycle, and the region erased for each erase type. The bench also shows, by reading the words just outside each region, that a stray start had no effect on the array.

// File: rtl/wse_pkg.sv
package wse_pkg;
  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_BLK  = 2'd2,
    OP_CHIP = 2'd3
  } wse_op_e;
endpackage

// File: rtl/wse_timer.sv
// Busy timer: latches the operation and counts its duration down.
module wse_timer
  import wse_pkg::*;
#(
  parameter int AW     = 8,
  parameter int DW     = 16,
  parameter int T_PROG = 20,
  parameter int T_SECT = 40,
  parameter int T_BLK  = 100,
  parameter int T_CHIP = 300
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_req,
  input  wse_op_e       start_op,
  input  logic [AW-1:0] start_addr,
  input  logic [DW-1:0] start_data,
  output logic          fire,
  output logic          busy,
  output logic          done,
  output logic          expire,
  output wse_op_e       op_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] data_q
);
  localparam int TM1  = (T_PROG > T_SECT) ? T_PROG : T_SECT;
  localparam int TM2  = (T_BLK > T_CHIP) ? T_BLK : T_CHIP;
  localparam int TMAX = (TM1 > TM2) ? TM1 : TM2;
  localparam int CW   = $clog2(TMAX + 1);

  logic [CW-1:0] cnt;

  function automatic logic [CW-1:0] dur_m1(wse_op_e o);
    case (o)
      OP_PROG: return CW'(T_PROG - 1);
      OP_SECT: return CW'(T_SECT - 1);
      OP_BLK:  return CW'(T_BLK - 1);
      default: return CW'(T_CHIP - 1);
    endcase
  endfunction

  assign fire   = start_req && !busy;
  assign expire = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      cnt    <= '0;
      op_q   <= OP_PROG;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      done <= 1'b0;
      if (fire) begin
        busy   <= 1'b1;
        cnt    <= dur_m1(start_op);
        op_q   <= start_op;
        addr_q <= start_addr;
        data_q <= start_data;
      end else if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  a_r2_done_idle: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  a_r2_done_single: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  a_r2_fall_done: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> done);
  a_r3_ignore_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && start_req) |=> ($stable(op_q) && $stable(addr_q) && $stable(data_q)));
endmodule

// File: rtl/wse_sweep.sv
// Erase walker: clears one word per cycle over the aligned region.
module wse_sweep
  import wse_pkg::*;
#(
  parameter int AW      = 8,
  parameter int SECT_AW = 4,
  parameter int BLK_AW  = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  wse_op_e       start_op,
  input  logic [AW-1:0] start_addr,
  output logic          sw_we,
  output logic [AW-1:0] sw_addr
);
  localparam logic [AW-1:0] SECT_MASK = AW'((1 << SECT_AW) - 1);
  localparam logic [AW-1:0] BLK_MASK  = AW'((1 << BLK_AW) - 1);
  localparam logic [AW-1:0] CHIP_MASK = '1;

  logic          act;
  logic [AW:0]   cnt;
  logic [AW:0]   last;
  logic [AW-1:0] base;
  logic [AW-1:0] mask;

  always_comb begin
    case (start_op)
      OP_SECT: mask = SECT_MASK;
      OP_BLK:  mask = BLK_MASK;
      default: mask = CHIP_MASK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act  <= 1'b0;
      cnt  <= '0;
      last <= '0;
      base <= '0;
    end else if (fire && start_op != OP_PROG) begin
      act  <= 1'b1;
      cnt  <= '0;
      last <= {1'b0, mask};
      base <= start_addr & ~mask;
    end else if (act) begin
      cnt <= cnt + 1'b1;
      if (cnt == last) act <= 1'b0;
    end
  end

  assign sw_we   = act;
  assign sw_addr = base | cnt[AW-1:0];

  a_r10_sweep_bounds: assert property (@(posedge clk) disable iff (rst) act |-> (cnt <= last));
endmodule

// File: rtl/wse_status.sv
// Status formatter: data-polling bit, toggle bit and read return flags.
module wse_status #(
  parameter int DW       = 16,
  parameter int POLL_BIT = 7,
  parameter int TGL_BIT  = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  logic          busy,
  input  logic          is_prog,
  input  logic          prog_bit,
  input  logic          rd_req,
  output logic [DW-1:0] stat_q,
  output logic          is_stat_q,
  output logic          valid_q
);
  logic          tgl;
  logic [DW-1:0] word;
  logic          stat_rd;

  assign stat_rd = rd_req && busy;

  always_comb begin
    word           = '0;
    word[POLL_BIT] = is_prog ? ~prog_bit : 1'b0;
    word[TGL_BIT]  = tgl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tgl       <= 1'b0;
      stat_q    <= '0;
      is_stat_q <= 1'b0;
      valid_q   <= 1'b0;
    end else begin
      valid_q   <= rd_req;
      is_stat_q <= stat_rd;
      if (stat_rd) stat_q <= word;
      if (fire) tgl <= 1'b0;
      else if (stat_rd) tgl <= ~tgl;
    end
  end

  a_r4_read_latency: assert property (@(posedge clk) disable iff (rst) rd_req |=> valid_q);
  a_r7_toggle_flip: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> (tgl != $past(tgl)));
  a_r7_toggle_clear: assert property (@(posedge clk) disable iff (rst) fire |=> !tgl);
endmodule

// File: rtl/wse_array.sv
// Behavioural array stub: one write port, one registered read port.
module wse_array #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdq
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdq <= mem[raddr];
  end
endmodule

// File: rtl/pgm_status_engine.sv
module pgm_status_engine
  import wse_pkg::*;
#(
  parameter int AW       = 8,
  parameter int DW       = 16,
  parameter int SECT_AW  = 4,
  parameter int BLK_AW   = 6,
  parameter int T_PROG   = 20,
  parameter int T_SECT   = 40,
  parameter int T_BLK    = 100,
  parameter int T_CHIP   = 300,
  parameter int POLL_BIT = 7,
  parameter int TGL_BIT  = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_req,
  input  logic [1:0]    start_op,
  input  logic [AW-1:0] start_addr,
  input  logic [DW-1:0] start_data,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          rd_is_status,
  output logic          busy,
  output logic          done
);
  wse_op_e       op_in;
  wse_op_e       op_q;
  logic          fire;
  logic          expire;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          sw_we;
  logic [AW-1:0] sw_addr;
  logic          pg_we;
  logic          arr_we;
  logic [AW-1:0] arr_waddr;
  logic [DW-1:0] arr_wdata;
  logic [DW-1:0] mem_q;
  logic [DW-1:0] stat_q;

  assign op_in = wse_op_e'(start_op);

  wse_timer #(
    .AW(AW), .DW(DW), .T_PROG(T_PROG), .T_SECT(T_SECT), .T_BLK(T_BLK), .T_CHIP(T_CHIP)
  ) u_timer (
    .clk(clk), .rst(rst), .start_req(start_req), .start_op(op_in),
    .start_addr(start_addr), .start_data(start_data), .fire(fire), .busy(busy),
    .done(done), .expire(expire), .op_q(op_q), .addr_q(addr_q), .data_q(data_q)
  );

  wse_sweep #(.AW(AW), .SECT_AW(SECT_AW), .BLK_AW(BLK_AW)) u_sweep (
    .clk(clk), .rst(rst), .fire(fire), .start_op(op_in), .start_addr(start_addr),
    .sw_we(sw_we), .sw_addr(sw_addr)
  );

  assign pg_we     = expire && (op_q == OP_PROG);
  assign arr_we    = pg_we || sw_we;
  assign arr_waddr = pg_we ? addr_q : sw_addr;
  assign arr_wdata = pg_we ? data_q : '1;

  wse_array #(.AW(AW), .DW(DW)) u_array (
    .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
    .re(rd_req), .raddr(rd_addr), .rdq(mem_q)
  );

  wse_status #(.DW(DW), .POLL_BIT(POLL_BIT), .TGL_BIT(TGL_BIT)) u_status (
    .clk(clk), .rst(rst), .fire(fire), .busy(busy), .is_prog(op_q == OP_PROG),
    .prog_bit(data_q[POLL_BIT]), .rd_req(rd_req), .stat_q(stat_q),
    .is_stat_q(rd_is_status), .valid_q(rd_valid)
  );

  assign rd_data = rd_is_status ? stat_q : mem_q;

  a_r10_sweep_in_busy: assert property (@(posedge clk) disable iff (rst) sw_we |-> busy);
  a_r9_one_writer: assert property (@(posedge clk) disable iff (rst) !(sw_we && pg_we));
  a_r6_erase_poll_low: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_is_status && op_q != OP_PROG) |-> !rd_data[POLL_BIT]);
endmodule

// File: tb/pgm_status_engine_bench.sv
module pgm_status_engine_bench;
  localparam int AW = 8, DW = 16, SAW = 4, BAW = 6;
  localparam int TP = 20, TS = 40, TB = 100, TC = 300;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst;
  logic          start_req;
  logic [1:0]    start_op;
  logic [AW-1:0] start_addr;
  logic [DW-1:0] start_data;
  logic          rd_req;
  logic [AW-1:0] rd_addr;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic          rd_is_status;
  logic          busy;
  logic          done;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] shadow [DEPTH];

  always #4 clk = ~clk;

  pgm_status_engine #(
    .AW(AW), .DW(DW), .SECT_AW(SAW), .BLK_AW(BAW),
    .T_PROG(TP), .T_SECT(TS), .T_BLK(TB), .T_CHIP(TC)
  ) u_pgm_status_engine (
    .clk(clk), .rst(rst), .start_req(start_req), .start_op(start_op),
    .start_addr(start_addr), .start_data(start_data), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_is_status(rd_is_status), .busy(busy), .done(done)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int dur_of(input int op);
    case (op)
      0: return TP;
      1: return TS;
      2: return TB;
      default: return TC;
    endcase
  endfunction

  function automatic int region_of(input int op);
    case (op)
      1: return 1 << SAW;
      2: return 1 << BAW;
      default: return DEPTH;
    endcase
  endfunction

  function automatic logic [DW-1:0] stat_word(input int op, input logic [DW-1:0] d,
                                              input bit tg);
    logic [DW-1:0] w;
    w = '0;
    w[7] = (op == 0) ? ~d[7] : 1'b0;
    w[6] = tg;
    return w;
  endfunction

  task automatic apply_shadow(input int op, input int a, input logic [DW-1:0] d);
    int n, base;
    if (op == 0) shadow[a] = d;
    else begin
      n = region_of(op);
      base = a & ~(n - 1);
      for (int i = 0; i < n; i++) shadow[base + i] = '1;
    end
  endtask

  task automatic idle_read(input int a, input string req);
    rd_req = 1'b1;
    rd_addr = AW'(a);
    @(posedge clk);
    @(negedge clk);
    rd_req = 1'b0;
    chk("R4", "idle rd_valid", 32'(rd_valid), 32'd1);
    chk("R8", "idle rd_is_status", 32'(rd_is_status), 32'd0);
    chk(req, $sformatf("data @%0h", a), 32'(rd_data), 32'(shadow[a]));
  endtask

  task automatic run_op(input int op, input int a, input logic [DW-1:0] d,
                        input int stray_k, input int rd_pct, input bit post);
    int  dur, n, base;
    bit  tg, r;
    string sreq;
    dur = dur_of(op);
    sreq = (op == 0) ? "R5" : "R6";
    start_req = 1'b1;
    start_op = 2'(op);
    start_addr = AW'(a);
    start_data = d;
    @(posedge clk);
    @(negedge clk);
    start_req = 1'b0;
    chk("R1", "busy after start", 32'(busy), 32'd1);
    chk("R2", "done after start", 32'(done), 32'd0);
    tg = 1'b0;
    for (int k = 1; k <= dur; k++) begin
      r = (($urandom % 100) < rd_pct) || (k == 1) || (k == dur);
      rd_req = r;
      rd_addr = AW'($urandom);
      if (k == stray_k) begin
        start_req = 1'b1;          // R3: stray start while busy
        start_op = (op == 3) ? 2'd0 : 2'd3;
        start_addr = AW'($urandom);
        start_data = DW'($urandom);
      end
      @(posedge clk);
      @(negedge clk);
      start_req = 1'b0;
      rd_req = 1'b0;
      chk((k == stray_k) ? "R3" : "R1", "busy length", 32'(busy), 32'(k < dur));
      chk("R2", "done pulse", 32'(done), 32'(k == dur));
      chk("R4", "status rd_valid", 32'(rd_valid), 32'(r));
      if (r) begin
        chk("R5", "rd_is_status", 32'(rd_is_status), 32'd1);
        chk(sreq, "status bit7", 32'(rd_data[7]), 32'(stat_word(op, d, tg)[7]));
        chk("R7", "status word", 32'(rd_data), 32'(stat_word(op, d, tg)));
        tg = ~tg;
      end
    end
    apply_shadow(op, a, d);
    if (post) begin
      n = region_of(op);
      base = a & ~(n - 1);
      idle_read((op == 0) ? a : base, (op == 0) ? "R9" : "R10");
      chk("R2", "done cleared", 32'(done), 32'd0);
      if (op != 0) begin
        idle_read(base + n - 1, "R10");
        if (base > 0) idle_read(base - 1, "R10");
        if (base + n < DEPTH) idle_read(base + n, "R10");
      end
    end
  endtask

  initial begin
    int unsigned sd;
    int op;
    for (int i = 0; i < DEPTH; i++) shadow[i] = '1;
    sd = $urandom(32'd2024);
    rst = 1'b1;
    start_req = 1'b0;
    start_op = 2'd0;
    start_addr = '0;
    start_data = '0;
    rd_req = 1'b0;
    rd_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R11", "reset busy", 32'(busy), 32'd0);
    chk("R11", "reset done", 32'(done), 32'd0);
    chk("R11", "reset rd_valid", 32'(rd_valid), 32'd0);
    idle_read(0, "R11");
    idle_read(DEPTH - 1, "R11");
    idle_read(37, "R11");

    // Directed programs: bit7 set and clear, every cycle read, stray start
    run_op(0, 8'h13, 16'h0080, 0, 100, 1'b1);
    run_op(0, 8'h14, 16'h1234, 3, 100, 1'b1);
    run_op(0, 8'h0F, 16'h5A5A, 0, 30, 1'b1);
    run_op(0, 8'h20, 16'hA5A5, 0, 30, 1'b1);
    // Sector erase around 0x13, neighbours 0x0F and 0x20 must survive
    run_op(1, 8'h13, 16'h0, 5, 60, 1'b1);
    idle_read(8'h14, "R10");
    // Back-to-back: next start issued in the done cycle
    run_op(0, 8'h40, 16'h00FF, 0, 50, 1'b0);
    run_op(0, 8'h7F, 16'hFF00, 0, 50, 1'b1);
    run_op(0, 8'h3F, 16'h1111, 0, 50, 1'b1);
    run_op(0, 8'h80, 16'h2222, 0, 50, 1'b1);
    run_op(2, 8'h45, 16'h0, 7, 40, 1'b1);
    idle_read(8'h40, "R10");

    // Random programs and mixed operations
    for (int i = 0; i < 12; i++)
      run_op(0, int'($urandom % DEPTH), DW'($urandom), (i % 3 == 0) ? 2 : 0, 50, 1'b1);
    for (int i = 0; i < 6; i++) begin
      op = (($urandom % 4) == 0) ? 1 + int'($urandom % 2) : 0;
      run_op(op, int'($urandom % DEPTH), DW'($urandom), 4, 50, 1'b1);
    end
    for (int i = 0; i < 8; i++) idle_read(int'($urandom % DEPTH), "R8");

    run_op(3, 8'h99, 16'h0, 10, 20, 1'b1);
    for (int i = 0; i < 6; i++) idle_read(int'($urandom % DEPTH), "R10");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule